// File: doc/BRIEF.md
# Vertical Character Line Repeater

This block produces the vertical timing for an on-screen character overlay. A leading edge on the vertical sync input restarts the frame. The block then lets a programmable number of horizontal lines pass and opens a display window. Inside that window every incoming line-start pulse is assigned a character row (0 to 14) and a font line within that row (0 to 17). Pixel generation and glyph lookup sit downstream and consume these indices.

Character height is stretched without a divider. A 7-bit height control chooses how many times each font line is emitted. The two upper bits set a base repeat that applies to every font line. Each of the five lower bits adds one extra copy to a fixed set of font lines, and those lines are spread evenly over the glyph. A per-row double-height flag, supplied by the caller for the row shown on `row_idx`, doubles the number of copies of every font line in that row.

Top module: `vcl_vert_repeater`

## Requirements
- R1: While reset is asserted and directly after it, `vde` is 0, `row_idx` is 0 and `font_line` is 0.
- R2: A rising edge on `vsync` (low in the previous clock, high now) forces `vde`, `row_idx` and `font_line` to 0 in the next cycle and restarts the delay from any state. A `line_start` sampled in that same clock is not counted.
- R3: After a `vsync` edge, the first `vdelay*4+1` line-start pulses keep `vde` at 0. The next pulse raises `vde` with `row_idx`=0 and `font_line`=0.
- R4: `height[6:5]` sets the base copy count of every font line: 0x gives 1 copy (18 lines per row), 10 gives 2 copies (36 lines) and 11 gives 3 copies (54 lines).
- R5: Each weight bit adds one copy to these font lines: `height[0]` to line 8; `height[1]` to lines 4 and 12; `height[2]` to lines 2, 6, 10 and 14; `height[3]` to the odd lines 1 to 15; `height[4]` to lines 1 to 16. A row therefore gains 1, 2, 4, 8 or 16 lines per bit.
- R6: When several weight bits are set, their extra copies add up per font line on top of the base count.
- R7: With `dbl_height` high during a row, every font line of that row is emitted twice as often. The flag is sampled on each line-start pulse.
- R8: During display, `font_line` steps 0 to 17. After line 17 the next row begins at font line 0. Rows run 0 to 14, and `row_idx` never exceeds 14 and `font_line` never exceeds 17.
- R9: After the last copy of font line 17 of row 14, the next line-start pulse drops `vde` to 0 with both indices at 0. They stay there until the next `vsync` edge.
- R10: The outputs are registered. They change only in the cycle after a sampled `line_start` or `vsync` edge, and they hold through idle cycles even if `vdelay` or `height` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each horizontal line |
| vsync | input | 1 | Vertical sync level; its rising edge starts a frame |
| vdelay | input | 8 | Vertical delay setting, in units of 4 lines (plus 1) |
| height | input | 7 | Height control: [6:5] base copies, [4:0] weight bits |
| dbl_height | input | 1 | Double-height flag for the row currently on `row_idx` |
| vde | output | 1 | Vertical display enable |
| row_idx | output | 4 | Character row index, 0 to 14 |
| font_line | output | 5 | Font line index within the row, 0 to 17 |

## Verification
Every result of this block is due one clock after the rising edge on which the line-start pulse or the sync edge was sampled, so the bench samples `vde`, `row_idx` and `font_line` on the falling edge that follows that rising edge. The driver pushes one expected triple per line-start pulse into a queue before it drives the pulse. The monitor pops that triple exactly half a cycle after the sampling edge, so stale or early values show up as mismatches. Frame totals are checked separately against the closed-form row height, and idle stretches are checked for unchanged outputs.

// File: rtl/vcl_pkg.sv
package vcl_pkg;

    // Sequencer phase of the vertical timing engine
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DELAY  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_DONE   = 2'd3
    } vcl_phase_e;

endpackage

// File: rtl/vcl_edge_det.sv
module vcl_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);

    logic sig_d;
    logic sig_q;

    always_comb begin
        sig_d = sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q <= 1'b0;
        end else begin
            sig_q <= sig_d;
        end
    end

    assign rise = sig & ~sig_q;

endmodule

// File: rtl/vcl_repeat_lut.sv
module vcl_repeat_lut #(
    parameter int FL_W  = 5,
    parameter int CH_W  = 7,
    parameter int REP_W = 4
) (
    input  logic [FL_W-1:0]  fline,
    input  logic [CH_W-1:0]  height,
    input  logic             dbl,
    output logic [REP_W-1:0] count
);

    // Number of weight bits below the two-bit base field
    localparam int NW   = CH_W - 2;
    // Span of font lines covered by the stride patterns
    localparam int CORE = 1 << (NW - 1);

    logic [NW-1:0]    hit;
    logic [REP_W-1:0] base;
    logic [REP_W-1:0] extra;
    logic [REP_W-1:0] per_line;

    // Top weight bit covers a contiguous span; lower bits pick lines
    // spaced by a power-of-two stride, centred in each stride window.
    for (genvar b = 0; b < NW; b++) begin : g_weight
        if (b == NW - 1) begin : g_span
            assign hit[b] = height[b] && (fline >= FL_W'(1)) && (fline <= FL_W'(CORE));
        end else begin : g_stride
            localparam int STRIDE = 1 << (NW - 1 - b);
            assign hit[b] = height[b] && (fline < FL_W'(CORE)) &&
                            ((fline & FL_W'(STRIDE - 1)) == FL_W'(STRIDE / 2));
        end
    end

    always_comb begin
        extra = '0;
        for (int i = 0; i < NW; i++) begin
            extra = extra + REP_W'(hit[i]);
        end
        if (height[CH_W-1]) begin
            base = height[CH_W-2] ? REP_W'(2) : REP_W'(1);
        end else begin
            base = '0;
        end
        per_line = REP_W'(1) + base + extra;
        count    = dbl ? REP_W'(per_line << 1) : per_line;
    end

endmodule

// File: rtl/vcl_vert_repeater.sv
module vcl_vert_repeater #(
    parameter int ROWS       = 15,
    parameter int FONT_LINES = 18,
    parameter int VD_W       = 8,
    parameter int CH_W       = 7,
    parameter int DELAY_MUL  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           line_start,
    input  logic                           vsync,
    input  logic [VD_W-1:0]                vdelay,
    input  logic [CH_W-1:0]                height,
    input  logic                           dbl_height,
    output logic                           vde,
    output logic [$clog2(ROWS)-1:0]        row_idx,
    output logic [$clog2(FONT_LINES)-1:0]  font_line
);

    import vcl_pkg::*;

    localparam int ROW_W  = $clog2(ROWS);
    localparam int FL_W   = $clog2(FONT_LINES);
    localparam int SKIP_W = VD_W + $clog2(DELAY_MUL) + 1;
    localparam int REP_W  = $clog2(2 * (1 + 2 + (CH_W - 2)) + 1);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [FL_W-1:0]  FL_LAST  = FL_W'(FONT_LINES - 1);

    typedef struct packed {
        vcl_phase_e        phase;
        logic [SKIP_W-1:0] skip;
        logic [ROW_W-1:0]  row;
        logic [FL_W-1:0]   fl;
        logic [REP_W-1:0]  rep;
        logic              vde;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic             vs_rise;
    logic [REP_W-1:0] line_cnt;
    logic [SKIP_W-1:0] skip_load;

    vcl_edge_det u_vs_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (vsync),
        .rise  (vs_rise)
    );

    vcl_repeat_lut #(
        .FL_W  (FL_W),
        .CH_W  (CH_W),
        .REP_W (REP_W)
    ) u_lut (
        .fline  (st_q.fl),
        .height (height),
        .dbl    (dbl_height),
        .count  (line_cnt)
    );

    assign skip_load = SKIP_W'(SKIP_W'(vdelay) * SKIP_W'(DELAY_MUL)) + SKIP_W'(1);

    always_comb begin
        st_d = st_q;
        if (vs_rise) begin
            st_d.phase = PH_DELAY;
            st_d.skip  = skip_load;
            st_d.row   = '0;
            st_d.fl    = '0;
            st_d.rep   = '0;
            st_d.vde   = 1'b0;
        end else if (line_start) begin
            unique case (st_q.phase)
                PH_DELAY: begin
                    if (st_q.skip == '0) begin
                        st_d.phase = PH_ACTIVE;
                        st_d.vde   = 1'b1;
                        st_d.row   = '0;
                        st_d.fl    = '0;
                        st_d.rep   = '0;
                    end else begin
                        st_d.skip = st_q.skip - SKIP_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (REP_W'(st_q.rep + REP_W'(1)) < line_cnt) begin
                        st_d.rep = st_q.rep + REP_W'(1);
                    end else begin
                        st_d.rep = '0;
                        if (st_q.fl == FL_LAST) begin
                            st_d.fl = '0;
                            if (st_q.row == ROW_LAST) begin
                                st_d.phase = PH_DONE;
                                st_d.vde   = 1'b0;
                                st_d.row   = '0;
                            end else begin
                                st_d.row = st_q.row + ROW_W'(1);
                            end
                        end else begin
                            st_d.fl = st_q.fl + FL_W'(1);
                        end
                    end
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vde       = st_q.vde;
    assign row_idx   = st_q.row;
    assign font_line = st_q.fl;

endmodule

// File: rtl/vcl_vert_repeater_chk.sv
module vcl_vert_repeater_chk #(
    parameter int ROWS       = 15,
    parameter int FONT_LINES = 18
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           line_start,
    input logic                           vsync,
    input logic                           vde,
    input logic [$clog2(ROWS)-1:0]        row_idx,
    input logic [$clog2(FONT_LINES)-1:0]  font_line
);

    localparam int ROW_W = $clog2(ROWS);
    localparam int FL_W  = $clog2(FONT_LINES);

    // R8
    index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_idx <= ROW_W'(ROWS - 1)) && (font_line <= FL_W'(FONT_LINES - 1)));

    // R2
    vsync_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |=> (!vde && row_idx == '0 && font_line == '0));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !$rose(vsync)) |=>
            ($stable(vde) && $stable(row_idx) && $stable(font_line)));

    // R3
    window_opens_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vde) |-> (row_idx == '0 && font_line == '0));

    // R8
    font_line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vde && line_start && !$rose(vsync)) |=>
            (font_line == $past(font_line) ||
             font_line == FL_W'($past(font_line) + FL_W'(1)) ||
             font_line == '0));

    // R9
    window_stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vde && line_start && !$rose(vsync) && row_idx != ROW_W'(ROWS - 1)) |=> vde);

endmodule

bind vcl_vert_repeater vcl_vert_repeater_chk #(
    .ROWS       (ROWS),
    .FONT_LINES (FONT_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .vsync      (vsync),
    .vde        (vde),
    .row_idx    (row_idx),
    .font_line  (font_line)
);

// File: tb/vcl_vert_repeater_tb.sv
module vcl_vert_repeater_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       vsync = 1'b0;
    logic [7:0] vdelay = 8'd0;
    logic [6:0] height = 7'd0;
    logic       dbl_height;
    logic       vde;
    logic [3:0] row_idx;
    logic [4:0] font_line;

    logic [14:0] dbl_mask = 15'd0;

    int checks = 0;
    int failures = 0;
    int vde_seen = 0;
    bit done = 1'b0;

    typedef struct {
        logic  vde;
        int    row;
        int    fl;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    assign dbl_height = dbl_mask[row_idx];

    vcl_vert_repeater u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .vsync      (vsync),
        .vdelay     (vdelay),
        .height     (height),
        .dbl_height (dbl_height),
        .vde        (vde),
        .row_idx    (row_idx),
        .font_line  (font_line)
    );

    task automatic check(input bit ok, input string tag, input string got, input string want);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s", tag, got, want);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Independent reference: copies of font line l in a row
    function automatic int copies(int l, logic [6:0] h, logic d);
        int n = 1;
        if (h[6]) n += h[5] ? 2 : 1;
        if (h[4] && l >= 1 && l <= 16) n++;
        if (h[3] && (l % 2) == 1 && l <= 15) n++;
        if (h[2] && (l == 2 || l == 6 || l == 10 || l == 14)) n++;
        if (h[1] && (l == 4 || l == 12)) n++;
        if (h[0] && l == 8) n++;
        return d ? 2 * n : n;
    endfunction

    // Closed-form lines per row from the weights
    function automatic int row_lines(logic [6:0] h, logic d);
        int base = h[6] ? (h[5] ? 3 : 2) : 1;
        int n = 18 * base + 16 * h[4] + 8 * h[3] + 4 * h[2] + 2 * h[1] + h[0];
        return d ? 2 * n : n;
    endfunction

    task automatic push(input logic v, input int r, input int f, input string tag);
        exp_t e;
        e.vde = v; e.row = r; e.fl = f; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic pulse_line();
        @(negedge clk) line_start = 1'b1;
        @(negedge clk) line_start = 1'b0;
    endtask

    task automatic sync_edge();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk);
        check(!vde && row_idx == 0 && font_line == 0, "R2 vsync edge",
              $sformatf("%0d/%0d/%0d", vde, row_idx, font_line), "0/0/0");
        vsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] vd, input logic [6:0] h, input logic [14:0] mask,
                             input bit do_vs, input string tag);
        int total;
        vdelay = vd; height = h; dbl_mask = mask;
        if (do_vs) sync_edge();
        vde_seen = 0;
        total = 0;
        for (int i = 0; i < vd * 4 + 1; i++) begin
            push(1'b0, 0, 0, "R3 delay line");
            pulse_line();
        end
        for (int r = 0; r < 15; r++) begin
            total += row_lines(h, mask[r]);
            for (int l = 0; l < 18; l++) begin
                for (int k = 0; k < copies(l, h, mask[r]); k++) begin
                    push(1'b1, r, l, tag);
                    pulse_line();
                end
            end
        end
        for (int i = 0; i < 3; i++) begin
            push(1'b0, 0, 0, "R9 after last row");
            pulse_line();
        end
        wait_drain();
        check(vde_seen == total, {tag, " frame height"},
              $sformatf("%0d", vde_seen), $sformatf("%0d", total));
    endtask

    // Monitor: one expected triple per sampled line-start pulse
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && line_start) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 scoreboard underflow", "extra pulse", "none");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (vde) vde_seen++;
                    check(vde == e.vde && row_idx == e.row && font_line == e.fl, e.tag,
                          $sformatf("%0d/%0d/%0d", vde, row_idx, font_line),
                          $sformatf("%0d/%0d/%0d", e.vde, e.row, e.fl));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", "finish");
        finish_up();
    end

    initial begin
        logic       sv_vde;
        logic [3:0] sv_row;
        logic [4:0] sv_fl;

        repeat (3) @(negedge clk);
        check(!vde && row_idx == 0 && font_line == 0, "R1 during reset",
              $sformatf("%0d/%0d/%0d", vde, row_idx, font_line), "0/0/0");
        rst_n = 1'b1;
        @(negedge clk);
        check(!vde && row_idx == 0 && font_line == 0, "R1 after reset",
              $sformatf("%0d/%0d/%0d", vde, row_idx, font_line), "0/0/0");

        // Before any vsync, line pulses leave the outputs idle (R9 idle state)
        push(1'b0, 0, 0, "R9 no frame yet");
        pulse_line();

        run_frame(8'd0, 7'b0000000, 15'h0000, 1'b1, "R4 R8 base 18");
        run_frame(8'd2, 7'b0011111, 15'h0000, 1'b1, "R5 R6 all weights");
        run_frame(8'd1, 7'b1000001, 15'h0000, 1'b1, "R4 R5 base 36 plus 1");
        run_frame(8'd0, 7'b1010110, 15'h5A5A, 1'b1, "R6 R7 mixed double");
        run_frame(8'd3, 7'b1100000, 15'h0000, 1'b1, "R4 base 54");
        run_frame(8'd0, 7'b1111111, 15'h7FFF, 1'b1, "R6 R7 max double");
        run_frame(8'd0, 7'b0001000, 15'h0001, 1'b1, "R5 R7 odd lines");

        // Abort a frame mid-display, with a line pulse sampled with the edge
        vdelay = 8'd0; height = 7'd0; dbl_mask = 15'd0;
        sync_edge();
        push(1'b0, 0, 0, "R3 delay line");
        pulse_line();
        for (int i = 0; i < 25; i++) begin
            push(1'b1, i / 18, i % 18, "R8 partial frame");
            pulse_line();
        end
        wait_drain();

        // R10: idle cycles with changed settings do not move the outputs
        sv_vde = vde; sv_row = row_idx; sv_fl = font_line;
        height = 7'b1111111; vdelay = 8'hFF;
        repeat (6) @(negedge clk);
        check(vde == sv_vde && row_idx == sv_row && font_line == sv_fl, "R10 hold while idle",
              $sformatf("%0d/%0d/%0d", vde, row_idx, font_line),
              $sformatf("%0d/%0d/%0d", sv_vde, sv_row, sv_fl));
        height = 7'd0;

        // R2: edge and line pulse in the same clock; that pulse is not counted
        vdelay = 8'd1;
        @(negedge clk);
        push(1'b0, 0, 0, "R2 pulse with edge ignored");
        vsync = 1'b1; line_start = 1'b1;
        @(negedge clk) line_start = 1'b0;
        check(!vde && row_idx == 0 && font_line == 0, "R2 mid-frame restart",
              $sformatf("%0d/%0d/%0d", vde, row_idx, font_line), "0/0/0");
        @(negedge clk) vsync = 1'b0;
        run_frame(8'd1, 7'b0000000, 15'h0000, 1'b0, "R2 R3 restarted frame");

        // Restart during the delay phase
        vdelay = 8'd2;
        sync_edge();
        for (int i = 0; i < 4; i++) begin
            push(1'b0, 0, 0, "R3 delay line");
            pulse_line();
        end
        wait_drain();
        run_frame(8'd0, 7'b0000100, 15'h0000, 1'b1, "R2 R5 restart in delay");

        finish_up();
    end

endmodule